// File: doc/BRIEF.md
# Fetch-Stage Dynamic Branch Predictor

This block sits beside the fetch stage of a pipelined processor and proposes the address to fetch next. It holds two tables that the fetch address indexes directly. One holds a 2-bit saturating confidence state for each entry. The other is a direct-mapped cache of branch destinations, with a valid bit and an address tag per entry. When the cache holds the fetched address and the state leans towards taken, the block steers fetch to the cached destination in the same cycle. In every other case it proposes the sequential address, the fetch address plus 4.

Later in the pipeline, the branch's real behaviour is reported on a resolve port: the branch address, whether it was taken, and where it went. In that cycle the block works out whether the guess it would have made for that address was wrong, and raises a mispredict strobe that the pipeline uses to flush. On the next clock edge it moves the confidence state one step towards the real outcome. A taken branch also writes its destination into the cache. Because of the 2-bit hysteresis, an inner-loop branch costs one miss per loop exit rather than two.

Top module: `bp_predictor`

## Requirements
- R1: After reset every confidence state is weakly not-taken (encoding 01) and every cache entry is invalid, so each fetch gives predTaken=0 and predNextPc=fetchPc+4.
- R2: Both tables are indexed by fetchPc[IDX_W+1:2], and the tag is fetchPc[PC_W-1:IDX_W+2]. predTaken is 1 exactly when the entry is valid, the tag matches, and the state's upper bit is 1. When predTaken is 1, predNextPc is the cached destination; otherwise it is fetchPc+4.
- R3: On each clock edge with resValid=1, the state at the index of resPc moves one step up (taken) or down (not taken). It saturates at 00 and 11 and uses the encoding 00 strong-not, 01 weak-not, 10 weak-taken, 11 strong-taken.
- R4: From a strong state, the predicted direction flips only after two consecutive outcomes against it.
- R5: A resolve with resTaken=1 writes valid, the tag of resPc and resTarget into the cache entry at the index of resPc. A not-taken resolve leaves the cache unchanged.
- R6: mispredict is 1, combinationally in the resolve cycle, exactly when resValid=1 and the next address that the pre-update tables give for resPc differs from the actual next address (resTarget if taken, resPc+4 if not).
- R7: A fetch in the same cycle as an update to the same entry sees the table contents from before the update.
- R8: A fetch whose index matches a valid entry but whose tag differs is a miss and gives fetchPc+4, whatever the shared state is.
- R9: For an inner-loop branch that is taken four times and then falls through, the predictor costs two misses in the first outer pass and one miss per later pass.
- R10: While resValid=0, no table changes and mispredict stays 0, whatever the other resolve inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchPc | input | PC_W | Address being fetched |
| predTaken | output | 1 | Fetch steered to cached destination |
| predNextPc | output | PC_W | Proposed next fetch address |
| resValid | input | 1 | A branch outcome is reported this cycle |
| resPc | input | PC_W | Address of the resolved branch |
| resTaken | input | 1 | Actual direction of the resolved branch |
| resTarget | input | PC_W | Actual destination of the resolved branch |
| mispredict | output | 1 | The earlier guess for resPc was wrong; flush |

## Verification
A directed walk through the states of a single branch separates correct saturation from wrap-around, and it shows that one opposite outcome does not flip a strong prediction. An aliasing address sets tag checking apart from index-only lookup. A resolve to the same address that is being fetched shows that the fetch reads the old contents. A nested-loop trace counts the misses per outer pass, which is the key difference between 2-bit and 1-bit behaviour. A seeded random mix of addresses with colliding indices, outcomes and idle cycles with noisy resolve inputs is then compared against a reference table model in every cycle.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic [1:0] {
    CTR_STRONG_NT = 2'b00,
    CTR_WEAK_NT   = 2'b01,
    CTR_WEAK_T    = 2'b10,
    CTR_STRONG_T  = 2'b11
  } ctrState_e;

  // strobes from control to the table datapath
  typedef struct packed {
    logic      ctrWe;
    ctrState_e ctrNext;
    logic      btbWe;
  } updStrobe_t;
endpackage

// File: rtl/bp_datapath.sv
module bp_datapath
  import bp_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] fetchPc,
  input  logic [PC_W-1:0] resPc,
  input  logic [PC_W-1:0] resTarget,
  input  updStrobe_t      strobe,
  output logic            predTaken,
  output logic [PC_W-1:0] predNextPc,
  output ctrState_e       resCtr,
  output logic [PC_W-1:0] resPredNext
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int TAG_W = PC_W - IDX_W - 2;
  localparam int TAG_LO = IDX_W + 2;

  ctrState_e        ctrTab    [DEPTH];
  logic [DEPTH-1:0] btbValid;
  logic [TAG_W-1:0] btbTag    [DEPTH];
  logic [PC_W-1:0]  btbTarget [DEPTH];

  logic [IDX_W-1:0] resIdx;
  logic [TAG_W-1:0] resTag;
  assign resIdx = resPc[IDX_W+1:2];
  assign resTag = resPc[PC_W-1:TAG_LO];

  // one storage slice per entry
  for (genvar e = 0; e < DEPTH; e++) begin : gEntry
    logic selHere;
    assign selHere = (resIdx == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        ctrTab[e]   <= CTR_WEAK_NT;
        btbValid[e] <= 1'b0;
        btbTag[e]   <= '0;
        btbTarget[e] <= '0;
      end else begin
        if (strobe.ctrWe && selHere) ctrTab[e] <= strobe.ctrNext;
        if (strobe.btbWe && selHere) begin
          btbValid[e]  <= 1'b1;
          btbTag[e]    <= resTag;
          btbTarget[e] <= resTarget;
        end
      end
    end
  end

  // fetch-side lookup
  logic [IDX_W-1:0] fetchIdx;
  logic [TAG_W-1:0] fetchTag;
  logic             fetchHit;
  ctrState_e        fetchCtr;
  assign fetchIdx = fetchPc[IDX_W+1:2];
  assign fetchTag = fetchPc[PC_W-1:TAG_LO];
  assign fetchCtr = ctrTab[fetchIdx];
  assign fetchHit = btbValid[fetchIdx] && (btbTag[fetchIdx] == fetchTag);

  always_comb begin
    predTaken  = fetchHit && fetchCtr[1];
    predNextPc = predTaken ? btbTarget[fetchIdx] : fetchPc + PC_W'(4);
  end

  // resolve-side lookup of the guess fetch would have made
  logic resHit;
  assign resCtr = ctrTab[resIdx];
  assign resHit = btbValid[resIdx] && (btbTag[resIdx] == resTag);

  always_comb begin
    if (resHit && resCtr[1]) resPredNext = btbTarget[resIdx];
    else                     resPredNext = resPc + PC_W'(4);
  end
endmodule

// File: rtl/bp_ctrl.sv
module bp_ctrl
  import bp_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            resValid,
  input  logic            resTaken,
  input  logic [PC_W-1:0] resPc,
  input  logic [PC_W-1:0] resTarget,
  input  ctrState_e       resCtr,
  input  logic [PC_W-1:0] resPredNext,
  output updStrobe_t      strobe,
  output logic            mispredict
);
  logic [PC_W-1:0] actualNext;
  ctrState_e       stepped;

  always_comb begin
    actualNext = resTaken ? resTarget : resPc + PC_W'(4);
    mispredict = resValid && (actualNext != resPredNext);
  end

  always_comb begin
    unique case (resCtr)
      CTR_STRONG_NT: stepped = resTaken ? CTR_WEAK_NT  : CTR_STRONG_NT;
      CTR_WEAK_NT:   stepped = resTaken ? CTR_WEAK_T   : CTR_STRONG_NT;
      CTR_WEAK_T:    stepped = resTaken ? CTR_STRONG_T : CTR_WEAK_NT;
      default:       stepped = resTaken ? CTR_STRONG_T : CTR_WEAK_T;
    endcase
  end

  always_comb begin
    strobe.ctrWe   = resValid;
    strobe.ctrNext = stepped;
    strobe.btbWe   = resValid && resTaken;
  end
endmodule

// File: rtl/bp_predictor.sv
module bp_predictor
  import bp_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] fetchPc,
  output logic            predTaken,
  output logic [PC_W-1:0] predNextPc,
  input  logic            resValid,
  input  logic [PC_W-1:0] resPc,
  input  logic            resTaken,
  input  logic [PC_W-1:0] resTarget,
  output logic            mispredict
);
  updStrobe_t      strobe;
  ctrState_e       resCtr;
  logic [PC_W-1:0] resPredNext;

  bp_ctrl #(.PC_W(PC_W)) ctrl_i (
    .resValid(resValid), .resTaken(resTaken), .resPc(resPc),
    .resTarget(resTarget), .resCtr(resCtr), .resPredNext(resPredNext),
    .strobe(strobe), .mispredict(mispredict)
  );

  bp_datapath #(.PC_W(PC_W), .IDX_W(IDX_W)) dp_i (
    .clk(clk), .rstN(rstN), .fetchPc(fetchPc), .resPc(resPc),
    .resTarget(resTarget), .strobe(strobe), .predTaken(predTaken),
    .predNextPc(predNextPc), .resCtr(resCtr), .resPredNext(resPredNext)
  );
endmodule

// File: rtl/bp_checker.sv
module bp_checker #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic [PC_W-1:0] fetchPc,
  input logic            predTaken,
  input logic [PC_W-1:0] predNextPc,
  input logic            resValid,
  input logic [PC_W-1:0] resPc,
  input logic            resTaken,
  input logic [PC_W-1:0] resTarget,
  input logic            mispredict
);
  AST_SEQ_WHEN_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    !predTaken |-> predNextPc == fetchPc + PC_W'(4)); // R2

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> !mispredict); // R10

  AST_IDLE_KEEPS_TABLES: assert property (@(posedge clk) disable iff (!rstN)
    !resValid ##1 $stable(fetchPc) |-> $stable(predTaken) && $stable(predNextPc)); // R10

  AST_TARGET_CACHED: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resTaken) ##1 (fetchPc == $past(resPc) && predTaken)
      |-> predNextPc == $past(resTarget)); // R5

  AST_AGREE_NO_MISP: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resPc == fetchPc &&
     predNextPc == (resTaken ? resTarget : resPc + PC_W'(4))) |-> !mispredict); // R6
endmodule

bind bp_predictor bp_checker #(.PC_W(PC_W)) chk_i (
  .clk(clk), .rstN(rstN), .fetchPc(fetchPc), .predTaken(predTaken),
  .predNextPc(predNextPc), .resValid(resValid), .resPc(resPc),
  .resTaken(resTaken), .resTarget(resTarget), .mispredict(mispredict)
);

// File: tb/bp_predictor_tb_top.sv
module bp_predictor_tb_top;
  localparam int PC_W  = 32;
  localparam int IDX_W = 4;
  localparam int DEPTH = 1 << IDX_W;

  logic            clk = 1'b0;
  logic            rstN;
  logic [PC_W-1:0] fetchPc;
  logic            predTaken;
  logic [PC_W-1:0] predNextPc;
  logic            resValid;
  logic [PC_W-1:0] resPc;
  logic            resTaken;
  logic [PC_W-1:0] resTarget;
  logic            mispredict;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #4 clk = ~clk; // 125 MHz

  bp_predictor #(.PC_W(PC_W), .IDX_W(IDX_W)) dut_i (.*);

  // reference tables
  logic [1:0]      mCtr [DEPTH];
  logic            mVld [DEPTH];
  logic [PC_W-1:0] mPcT [DEPTH];
  logic [PC_W-1:0] mTgt [DEPTH];

  function automatic int idxOf(logic [PC_W-1:0] pc);
    return int'(pc[IDX_W+1:2]);
  endfunction

  function automatic bit mTaken(logic [PC_W-1:0] pc);
    int i = idxOf(pc);
    return mVld[i] && (mPcT[i][PC_W-1:IDX_W+2] == pc[PC_W-1:IDX_W+2]) && mCtr[i][1];
  endfunction

  function automatic logic [PC_W-1:0] mNext(logic [PC_W-1:0] pc);
    return mTaken(pc) ? mTgt[idxOf(pc)] : pc + 4;
  endfunction

  task automatic chk(bit ok, string req, logic [PC_W-1:0] act, logic [PC_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: drive at falling edge, compare, let the rising edge update
  task automatic step(input logic [PC_W-1:0] fpc, input bit rv, input bit rt,
                      input logic [PC_W-1:0] rpc, input logic [PC_W-1:0] rtg,
                      output bit misp);
    bit expMisp;
    logic [PC_W-1:0] actNext;
    @(negedge clk);
    fetchPc = fpc; resValid = rv; resTaken = rt; resPc = rpc; resTarget = rtg;
    #1;
    chk(predTaken == mTaken(fpc), "R2 predTaken", PC_W'(predTaken), PC_W'(mTaken(fpc)));
    chk(predNextPc == mNext(fpc), "R2 predNextPc", predNextPc, mNext(fpc));
    actNext = rt ? rtg : rpc + 4;
    expMisp = rv && (actNext != mNext(rpc));
    chk(mispredict == expMisp, rv ? "R6 mispredict" : "R10 mispredict idle",
        PC_W'(mispredict), PC_W'(expMisp));
    misp = mispredict;
    @(posedge clk);
    if (rv) begin
      int i = idxOf(rpc);
      if (rt) begin
        if (mCtr[i] != 2'b11) mCtr[i] = mCtr[i] + 1;
        mVld[i] = 1; mPcT[i] = rpc; mTgt[i] = rtg;
      end else if (mCtr[i] != 2'b00) mCtr[i] = mCtr[i] - 1;
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    bit m;
    int innerMisp;
    int passMisp;
    logic [PC_W-1:0] pA, pB, pC, pD, pL;
    for (int i = 0; i < DEPTH; i++) begin
      mCtr[i] = 2'b01; mVld[i] = 0; mPcT[i] = '0; mTgt[i] = '0;
    end
    rstN = 0; fetchPc = '0; resValid = 0; resTaken = 0; resPc = '0; resTarget = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;

    // R1: reset state
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); fetchPc = 32'h1000 + 32'(k * 4); #1;
      chk(!predTaken, "R1 predTaken", PC_W'(predTaken), 0);
      chk(predNextPc == fetchPc + 4, "R1 predNextPc", predNextPc, fetchPc + 4);
    end

    // R3/R4: walk one branch through its states
    pA = 32'h40;
    step(pA, 1, 1, pA, 32'h100, m); chk(m == 1, "R6 first taken", PC_W'(m), 1);
    step(pA, 0, 0, 0, 0, m);
    chk(predTaken && predNextPc == 32'h100, "R5 cached target", predNextPc, 32'h100);
    step(pA, 1, 1, pA, 32'h100, m); chk(m == 0, "R3 strong taken", PC_W'(m), 0);
    step(pA, 1, 1, pA, 32'h100, m); chk(m == 0, "R3 saturate high", PC_W'(m), 0);
    step(pA, 1, 0, pA, 32'h100, m); chk(m == 1, "R4 first wrong", PC_W'(m), 1);
    step(pA, 0, 0, 0, 0, m); chk(predTaken == 1, "R4 holds after one", PC_W'(predTaken), 1);
    step(pA, 1, 0, pA, 32'h100, m); chk(m == 1, "R4 second wrong", PC_W'(m), 1);
    step(pA, 0, 0, 0, 0, m); chk(predTaken == 0, "R4 flips after two", PC_W'(predTaken), 0);
    step(pA, 1, 0, pA, 0, m); step(pA, 1, 0, pA, 0, m); step(pA, 1, 0, pA, 0, m);
    step(pA, 1, 1, pA, 32'h100, m); chk(m == 1, "R3 saturate low", PC_W'(m), 1);
    step(pA, 0, 0, 0, 0, m); chk(predTaken == 0, "R3 one step from 00", PC_W'(predTaken), 0);

    // R8: aliasing address with another tag
    step(pA, 1, 1, pA, 32'h100, m); step(pA, 1, 1, pA, 32'h100, m);
    pB = pA + 32'(1 << (IDX_W + 2));
    step(pB, 0, 0, 0, 0, m);
    chk(!predTaken && predNextPc == pB + 4, "R8 tag miss", predNextPc, pB + 4);

    // R7: fetch during an update to the same entry sees the old contents
    pC = 32'h0C;
    step(pC, 1, 1, pC, 32'h200, m);
    chk(m == 1, "R7 resolve in same cycle", PC_W'(m), 1);
    step(pC, 1, 1, pC, 32'h200, m);
    chk(m == 0, "R7 visible next cycle", PC_W'(m), 0);

    // R5: not-taken resolve leaves the cached destination
    step(pC, 1, 0, pC, 32'h999, m);
    step(pC, 0, 0, 0, 0, m);
    chk(predNextPc == 32'h200, "R5 not-taken keeps cache", predNextPc, 32'h200);

    // R10: noisy resolve inputs with resValid low
    pD = 32'h10;
    for (int k = 0; k < 5; k++) step(pD, 0, 1, pD, 32'h300, m);
    step(pD, 0, 0, 0, 0, m);
    chk(!predTaken && predNextPc == pD + 4, "R10 idle no write", predNextPc, pD + 4);

    // R9: nested loop, inner taken 4 times then exit
    pL = 32'h24; innerMisp = 0;
    for (int o = 0; o < 5; o++) begin
      passMisp = 0;
      for (int it = 0; it < 5; it++) begin
        step(pL, 1, (it < 4), pL, 32'h18, m);
        passMisp += int'(m);
      end
      step(32'h38, 1, (o < 4), 32'h38, 32'h14, m);
      chk(passMisp == ((o == 0) ? 2 : 1), "R9 misses per pass",
          PC_W'(passMisp), PC_W'((o == 0) ? 2 : 1));
      innerMisp += passMisp;
    end
    chk(innerMisp == 6, "R9 total inner misses", PC_W'(innerMisp), 6);

    // random mix of colliding addresses, outcomes and idle cycles
    void'($urandom(32'd2024));
    for (int k = 0; k < 800; k++) begin
      logic [PC_W-1:0] rp, fp;
      rp = {28'($urandom_range(0, 1)), 4'($urandom_range(0, 3)), 2'b00} << 0;
      rp = (32'($urandom_range(0, 1)) << (IDX_W + 2)) | (32'($urandom_range(0, 3)) << 2);
      fp = (32'($urandom_range(0, 1)) << (IDX_W + 2)) | (32'($urandom_range(0, 3)) << 2);
      step(fp, ($urandom_range(0, 3) != 0), $urandom_range(0, 1), rp,
           32'h4000 + (32'($urandom_range(0, 3)) << 4), m);
    end

    finishRun();
  end
endmodule